// File: doc/BRIEF.md
# Daisy-Chain LED Frame Receiver

This block is the serial front end of one LED driver in a chain of identical drivers. Every driver in the chain runs from the same clock, which never stops between frames. A frame arrives as a serial bit stream, framed by a load line that is high for the whole frame and low while the line is idle. Each frame carries an 8-bit header, sent most significant bit first, followed by a data segment and an optional 8-bit tail. Header bit 0 set to 1 announces the tail.

The driver keeps the first 128 data bits for itself. These are 16 channels of 8 bits each, and the driver presents them as one parallel intensity word with a single-cycle latch strobe. It passes on to the next device everything it does not keep. The header and the tail go to every device in the chain, while the data segment loses 128 bits at each hop. While it takes in its own share, the block holds its serial and load outputs low. It then replays the stored header just in time for the rest of the frame, which follows with one cycle of latency. The next device therefore sees a well-formed frame that starts with the header and is 128 data bits shorter.

The frame interface is a stream with no back-pressure. The load line acts as the valid qualifier and there is no ready, because the shared clock never pauses and each device must accept one bit per cycle. The downstream side obeys the same rule: the block produces one bit per cycle whenever its load output is high.

Top module: `daisy_frame_rx`

## Requirements
- R1: The serial and load inputs are sampled only at rising clock edges. The serial and load outputs come straight from registers.
- R2: After synchronous active-high reset, the serial output, load output, latch strobe and intensity word are all 0.
- R3: If the load input first goes high at cycle 0, the load output stays low after edges 0 to 127. From edge 128 on, the load output equals the load input sampled at that same edge.
- R4: While the 128 share bits are taken in, the serial output carries none of them. After edges 128 to 135 the serial output replays the 8 header bits in order, MSB first.
- R5: Data bits after the share, and the tail if present, appear on the serial output one cycle after they are sampled.
- R6: Share byte c (c = 0..15, in arrival order, first bit received = bit 7) is placed in intensity word bits [8c+7:8c].
- R7: When the load input is sampled low after a frame whose share completed, the latch strobe is high for exactly one cycle after that edge. The intensity word takes its new value in that same cycle.
- R8: When header bit 0 is 1, the strobe needs at least 8 further bits after the share. A shorter frame gives no strobe.
- R9: A frame that ends during the header or the share gives no strobe and leaves the intensity word unchanged. The outputs return low one cycle after the load input is sampled low.
- R10: The intensity word changes only in a strobe cycle.
- R11: Frames separated by a single idle cycle are both received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared, free-running chain clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial frame data from the upstream device |
| load_in | input | 1 | Frame qualifier from upstream, high for the whole frame |
| ser_out | output | 1 | Retimed serial data to the next device |
| load_out | output | 1 | Retimed frame qualifier to the next device |
| chan_word | output | 128 | 16 channel intensities, channel c in bits [8c+7:8c] |
| latch_stb | output | 1 | One-cycle pulse when a new intensity word is valid |

## Verification
The bench targets the edges of the consumed share. It sends frames whose data segment holds exactly 128 bits, stops four bits short, or stops inside the header replay. A design with an off-by-one count would strobe on a short frame, miss the exact one, or shift the replayed header by a slot. Frames with the tail flag and too few trailing bits catch a design that ignores header bit 0 and latches tail bits as channel data. Back-to-back frames with a single idle cycle catch state that fails to clear in time, and comparing the word in the cycles just before and after the strobe catches a word that updates early or late.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_SHARE,
    ST_PASS
  } dfr_state_e;
endpackage

// File: rtl/dfr_seq.sv
module dfr_seq
  import dfr_pkg::*;
#(
  parameter int SB = 128,
  parameter int HW = 8,
  parameter int TW = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld_in,
  input  logic       sd_in,
  output dfr_state_e st,
  output logic       share_en,
  output logic       replay_on,
  output logic       replay_bit,
  output logic       commit
);
  localparam int CNTW = $clog2(SB);
  localparam int REMW = $clog2(TW + 1);
  localparam int REPLAY_START = SB - HW;

  logic [CNTW-1:0] cnt;
  logic [REMW-1:0] rem;
  logic [HW-1:0]   rep;
  logic            tail_q;

  always_comb begin
    share_en   = (st == ST_SHARE) && ld_in;
    replay_on  = share_en && (cnt >= CNTW'(REPLAY_START));
    replay_bit = rep[HW-1];
    commit     = (st == ST_PASS) && !ld_in && (!tail_q || rem == REMW'(TW));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      rem    <= '0;
      rep    <= '0;
      tail_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ld_in) begin
            rep <= {rep[HW-2:0], sd_in};
            cnt <= CNTW'(1);
            st  <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (!ld_in) begin
            st <= ST_IDLE;
          end else begin
            rep <= {rep[HW-2:0], sd_in};
            cnt <= cnt + 1'b1;
            if (cnt == CNTW'(HW - 1)) begin
              st     <= ST_SHARE;
              cnt    <= '0;
              tail_q <= sd_in;
              rem    <= '0;
            end
          end
        end
        ST_SHARE: begin
          if (!ld_in) begin
            st <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            if (replay_on) rep <= {rep[HW-2:0], 1'b0};
            if (cnt == CNTW'(SB - 1)) st <= ST_PASS;
          end
        end
        ST_PASS: begin
          if (!ld_in) st <= ST_IDLE;
          else if (rem != REMW'(TW)) rem <= rem + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dfr_fwd.sv
module dfr_fwd
  import dfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dfr_state_e st,
  input  logic       ld_in,
  input  logic       sd_in,
  input  logic       replay_on,
  input  logic       replay_bit,
  output logic       sd_out,
  output logic       ld_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sd_out <= 1'b0;
      ld_out <= 1'b0;
    end else if (st == ST_PASS) begin
      sd_out <= ld_in & sd_in;
      ld_out <= ld_in;
    end else if (replay_on) begin
      sd_out <= replay_bit;
      ld_out <= 1'b1;
    end else begin
      sd_out <= 1'b0;
      ld_out <= 1'b0;
    end
  end
endmodule

// File: rtl/dfr_share.sv
module dfr_share #(
  parameter int NCH = 16,
  parameter int CW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              share_en,
  input  logic              sd_in,
  input  logic              commit,
  output logic [NCH*CW-1:0] word,
  output logic              stb
);
  localparam int SB = NCH * CW;

  logic [SB-1:0] share_sr;
  logic [SB-1:0] word_nx;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign word_nx[c*CW +: CW] = share_sr[SB-1-c*CW -: CW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      share_sr <= '0;
      word     <= '0;
      stb      <= 1'b0;
    end else begin
      if (share_en) share_sr <= {share_sr[SB-2:0], sd_in};
      if (commit) word <= word_nx;
      stb <= commit;
    end
  end
endmodule

// File: rtl/daisy_frame_rx.sv
module daisy_frame_rx
  import dfr_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CW  = 8,
  parameter int HW  = 8,
  parameter int TW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              load_in,
  output logic              ser_out,
  output logic              load_out,
  output logic [NCH*CW-1:0] chan_word,
  output logic              latch_stb
);
  localparam int SB = NCH * CW;

  dfr_state_e st;
  logic share_en, replay_on, replay_bit, commit;

  dfr_seq #(.SB(SB), .HW(HW), .TW(TW)) u_seq (
    .clk(clk), .rst(rst), .ld_in(load_in), .sd_in(ser_in), .st(st),
    .share_en(share_en), .replay_on(replay_on), .replay_bit(replay_bit),
    .commit(commit)
  );

  dfr_fwd u_fwd (
    .clk(clk), .rst(rst), .st(st), .ld_in(load_in), .sd_in(ser_in),
    .replay_on(replay_on), .replay_bit(replay_bit),
    .sd_out(ser_out), .ld_out(load_out)
  );

  dfr_share #(.NCH(NCH), .CW(CW)) u_share (
    .clk(clk), .rst(rst), .share_en(share_en), .sd_in(ser_in),
    .commit(commit), .word(chan_word), .stb(latch_stb)
  );
endmodule

// File: rtl/dfr_chk.sv
module dfr_chk #(
  parameter int WW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          load_in,
  input logic          ser_out,
  input logic          load_out,
  input logic [WW-1:0] chan_word,
  input logic          latch_stb
);
  // R3
  load_out_follows_chk: assert property (@(posedge clk) disable iff (rst)
    load_out |-> $past(load_in));

  // R5
  data_only_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    ser_out |-> load_out);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> !latch_stb);

  // R7
  strobe_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    latch_stb |-> !$past(load_in) && $past(load_in, 2));

  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_stb |-> $stable(chan_word));
endmodule

bind daisy_frame_rx dfr_chk #(.WW(NCH*CW)) u_dfr_chk (
  .clk(clk), .rst(rst), .load_in(load_in), .ser_out(ser_out),
  .load_out(load_out), .chan_word(chan_word), .latch_stb(latch_stb)
);

// File: tb/test_daisy_frame_rx.sv
module test_daisy_frame_rx;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_in = 1'b0;
  logic         load_in = 1'b0;
  logic         ser_out, load_out, latch_stb;
  logic [127:0] chan_word;

  int n_chk = 0;
  int n_bad = 0;
  logic [127:0] exp_word = '0;

  logic in_sd [0:511];
  logic o_sd  [0:511];
  logic o_ld  [0:511];
  logic o_stb [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  daisy_frame_rx i_daisy_frame_rx (
    .clk(clk), .rst(rst), .ser_in(ser_in), .load_in(load_in),
    .ser_out(ser_out), .load_out(load_out), .chan_word(chan_word),
    .latch_stb(latch_stb)
  );

  function automatic logic [7:0] pat(input int seed, input int idx);
    return 8'(seed * 7 + idx * 29 + (idx >> 1) + 5);
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One frame: hb header bits (8 = full), ab bits after the header, gap idle slots.
  task automatic run_frame(input logic [7:0] hdr, input int hb, input int ab,
                           input int seed, input int gap);
    int f;
    bit full;
    logic [127:0] w_before, w_after, new_word;
    int bad_ld, bad_sd, bad_stb, first_ld, first_sd, first_stb;
    f = (hb < 8) ? hb : 8 + ab;
    full = (hb == 8) && ((ab - (hdr[0] ? 8 : 0)) >= 128);
    for (int k = 0; k < f; k++) begin
      if (k < 8) in_sd[k] = hdr[7-k];
      else begin
        int j = k - 8;
        logic [7:0] b = (j / 8 < 16) ? pat(seed, j / 8) : pat(seed + 99, j / 8);
        in_sd[k] = b[7 - (j % 8)];
      end
    end
    for (int c = 0; c < 16; c++) new_word[c*8 +: 8] = pat(seed, c);
    w_before = chan_word;
    w_after  = chan_word;
    for (int k = 0; k < f + gap; k++) begin
      @(negedge clk);
      ser_in  = (k < f) ? in_sd[k] : 1'b0;
      load_in = (k < f);
      @(posedge clk);
      #2;
      o_sd[k]  = ser_out;
      o_ld[k]  = load_out;
      o_stb[k] = latch_stb;
      if (k == f - 1) w_before = chan_word;
      if (k == f) w_after = chan_word;
    end
    bad_ld = 0; bad_sd = 0; bad_stb = 0;
    first_ld = -1; first_sd = -1; first_stb = -1;
    for (int k = 0; k < f + gap; k++) begin
      logic e_ld, e_sd, e_stb;
      e_ld = (k < f) && (k >= 128);
      if (k < f && k >= 128 && k < 136) e_sd = hdr[7 - (k - 128)];
      else if (k < f && k >= 136) e_sd = in_sd[k];
      else e_sd = 1'b0;
      e_stb = full && (k == f);
      if (o_ld[k] !== e_ld) begin bad_ld++; if (first_ld < 0) first_ld = k; end
      if (o_sd[k] !== e_sd) begin bad_sd++; if (first_sd < 0) first_sd = k; end
      if (o_stb[k] !== e_stb) begin bad_stb++; if (first_stb < 0) first_stb = k; end
    end
    // R3 load output gating and one-cycle copy
    check(bad_ld == 0, $sformatf("R3 load_out slot %0d", first_ld), 128'(bad_ld), 0);
    // R4 R5 share silence, header replay, pass-through
    check(bad_sd == 0, $sformatf("R4/R5 ser_out slot %0d", first_sd), 128'(bad_sd), 0);
    // R7 R8 R9 strobe timing and presence
    check(bad_stb == 0, $sformatf("R7/R8/R9 latch_stb slot %0d", first_stb),
          128'(bad_stb), 0);
    if (full) begin
      check(w_before == exp_word, "R10 word before strobe", w_before, exp_word);
      check(w_after == new_word, "R6 word at strobe", w_after, new_word);
      exp_word = new_word;
    end else begin
      check(w_after == exp_word, "R9 word kept on short frame", w_after, exp_word);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; load_in = 1'b1; ser_in = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R2 outputs cleared even with inputs high
    check({ser_out, load_out, latch_stb} == 3'b000, "R2 outputs in reset",
          128'({ser_out, load_out, latch_stb}), 0);
    check(chan_word == '0, "R2 word in reset", chan_word, '0);
    @(negedge clk);
    load_in = 1'b0; ser_in = 1'b0; rst = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    // R1 nothing sampled while idle
    check({ser_out, load_out, latch_stb} == 3'b000, "R1 idle after reset",
          128'({ser_out, load_out, latch_stb}), 0);
  endtask

  task automatic t_full_no_tail;   run_frame(8'hA4, 8, 128 + 16, 3, 3);  endtask
  task automatic t_exact_share;    run_frame(8'h5A, 8, 128, 11, 2);      endtask
  task automatic t_tail_ok;        run_frame(8'hC3, 8, 128 + 16, 21, 2); endtask // R8
  task automatic t_tail_short;     run_frame(8'h81, 8, 128 + 5, 33, 2);  endtask // R8
  task automatic t_short_share;    run_frame(8'h60, 8, 50, 41, 2);       endtask // R9
  task automatic t_short_replay;   run_frame(8'h3C, 8, 124, 45, 2);      endtask // R9
  task automatic t_short_header;   run_frame(8'hF0, 3, 0, 49, 2);        endtask // R9
  task automatic t_back_to_back;   // R11
    run_frame(8'h96, 8, 136, 57, 1);
    run_frame(8'h18, 8, 128, 63, 4);
  endtask

  initial begin
    t_reset();
    t_full_no_tail();
    t_exact_share();
    t_tail_ok();
    t_tail_short();
    t_short_share();
    t_short_replay();
    t_short_header();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule